// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Interval Timer

This block holds two 8-bit up-counters. Each counter has its own compare register. A 2-bit mode field selects one of two arrangements. In the first, the counters run as two separate interval timers. The high timer can be clocked by the low timer's match pulse, which chains them. In the second, the two counters join into a single 16-bit interval timer. The low counter's carry out drives the high counter, and the period is spread across both compare registers, low byte in the low register.

All logic runs on the system clock. Counting is gated by clock enables rather than derived clocks. The low timer counts on the external tick or on one of three prescaler taps. The high timer takes the low timer's match pulse or one of the same taps. The block raises single-cycle interrupt pulses and drives a toggle flip-flop output. The compare registers can only be loaded while the run enable is low, and the counters sit at zero while it is low. The block has no streaming interface: every pin is a plain control or status level.

Top module: `dual_tmr_top`

## Requirements
- R1: After reset, both counts, both interrupt outputs and `tff_q` are 0, and both compare registers hold 00h.
- R2: Mode 00 selects separate 8-bit timers, and so do the unused values 10 and 11. In these modes, each selected tick on the low timer raises `lo_count` by one. When the next value equals the low compare value, `lo_count` returns to 00h instead, and `irq_lo` is high for exactly one cycle after that edge.
- R3: `lo_src` picks the low timer's tick: 0 = `ext_tick`, 1 = `tap_en[0]`, 2 = `tap_en[1]`, 3 = `tap_en[2]`. Pulses on the sources that are not selected leave `lo_count` unchanged.
- R4: In the 8-bit modes, `hi_src` picks the high timer's tick: 0 = the low timer's match pulse, 1 to 3 = taps 0 to 2. The high timer resets to 00h on its own compare match and raises `irq_hi` for one cycle.
- R5: In mode 01, `hi_count` increments only when `lo_count` rolls from FFh to 00h, and `hi_src` has no effect.
- R6: In mode 01, `lo_count` passes through its own compare value without resetting, and `irq_lo` stays low.
- R7: In mode 01, both counters return to 00h when the low and high matches occur on the same tick, and `irq_hi` pulses. The interrupt period is therefore {hi compare, lo compare} ticks; for example, 0480h gives 1152 ticks.
- R8: `tff_q` inverts on each `irq_hi` event while `tff_en` is high and holds its value otherwise.
- R9: A compare-register write while `run` is high is ignored.
- R10: While `run` is low, both counters are 00h and ignore ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| run | input | 1 | Run enable; low clears and holds both counters |
| mode | input | 2 | 01 = cascaded 16-bit, otherwise two 8-bit timers |
| lo_src | input | 2 | Low timer tick select |
| hi_src | input | 2 | High timer tick select (8-bit modes only) |
| ext_tick | input | 1 | External count enable, one cycle per count |
| tap_en | input | 3 | Prescaler tap enables |
| lo_cmp_we | input | 1 | Write strobe, low compare register |
| hi_cmp_we | input | 1 | Write strobe, high compare register |
| cmp_wdata | input | 8 | Compare write data |
| tff_en | input | 1 | Enables toggling of the timer flip-flop |
| lo_count | output | 8 | Low counter value |
| hi_count | output | 8 | High counter value |
| irq_lo | output | 1 | Low timer match pulse |
| irq_hi | output | 1 | High timer / 16-bit match pulse |
| tff_q | output | 1 | Timer flip-flop output |

## Verification
The bench runs a 16-bit period of 0480h and checks the count just before and just after the low byte first matches. A design that reset the low counter on its own match would show 01h instead of 81h at that point. Such a design, or one that raised `irq_lo` in cascade mode, is caught there. The bench also checks that no interrupt arrives one tick before the full period and that exactly one arrives on the last tick, which catches off-by-one and wrong-carry errors. It holds a tap active while `hi_src` points at it in cascade mode, writes a compare register during a run, and pulses unselected sources. Each of these would show up as a shifted count or a shifted period if the block did not ignore it.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL8  = 2'b00,
    MODE_CASC16 = 2'b01,
    MODE_RSV2   = 2'b10,
    MODE_RSV3   = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_src_sel.sv
// Picks one count enable out of a primary source and NTAP taps.
module tmr_src_sel #(
  parameter int NTAP = 3,
  parameter int SW   = $clog2(NTAP + 1)
) (
  input  logic [SW-1:0]   sel,
  input  logic            primary,
  input  logic [NTAP-1:0] taps,
  output logic            tick
);
  logic [NTAP:0] cand;

  assign cand[0] = primary;
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign cand[g+1] = taps[g];
  end

  always_comb begin
    tick = 1'b0;
    if (int'(sel) <= NTAP) tick = cand[sel];
  end
endmodule

// File: rtl/tmr_unit8.sv
// One up-counter with its compare register.
module tmr_unit8 #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          auto_rst,
  input  logic          force_clr,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp,
  output logic          hit,
  output logic          wrap
);
  logic [CW-1:0] nxt;

  assign nxt  = cnt + {{(CW-1){1'b0}}, tick};
  assign hit  = (nxt == cmp);
  assign wrap = tick && (cnt == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || force_clr) begin
      cnt <= '0;
    end else if (tick && hit && auto_rst) begin
      cnt <= '0;
    end else begin
      cnt <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (wr_en && !run) begin
      cmp <= wr_data;
    end
  end
endmodule

// File: rtl/tmr_evt_out.sv
// Registers the interrupt pulses and the toggle flip-flop.
module tmr_evt_out (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_evt,
  input  logic hi_evt,
  input  logic tff_en,
  output logic irq_lo,
  output logic irq_hi,
  output logic tff_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
      tff_q  <= 1'b0;
    end else begin
      irq_lo <= lo_evt;
      irq_hi <= hi_evt;
      if (hi_evt && tff_en) tff_q <= ~tff_q;
    end
  end
endmodule

// File: rtl/dual_tmr_top.sv
module dual_tmr_top #(
  parameter int CW   = 8,
  parameter int NTAP = 3,
  parameter int SW   = $clog2(NTAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [1:0]      mode,
  input  logic [SW-1:0]   lo_src,
  input  logic [SW-1:0]   hi_src,
  input  logic            ext_tick,
  input  logic [NTAP-1:0] tap_en,
  input  logic            lo_cmp_we,
  input  logic            hi_cmp_we,
  input  logic [CW-1:0]   cmp_wdata,
  input  logic            tff_en,
  output logic [CW-1:0]   lo_count,
  output logic [CW-1:0]   hi_count,
  output logic            irq_lo,
  output logic            irq_hi,
  output logic            tff_q
);
  import dual_tmr_pkg::*;

  tmr_mode_e     mode_e;
  logic          casc;
  logic          lo_sel_tick, hi_sel_tick;
  logic          lo_tick, hi_tick;
  logic          lo_hit, hi_hit, lo_wrap, hi_wrap;
  logic          lo_match_ev, hi_match_ev, joint_match;
  logic [CW-1:0] lo_cmp_q, hi_cmp_q;

  assign mode_e = tmr_mode_e'(mode);
  assign casc   = (mode_e == MODE_CASC16);

  tmr_src_sel #(.NTAP(NTAP), .SW(SW)) u_lo_sel (
    .sel(lo_src), .primary(ext_tick), .taps(tap_en), .tick(lo_sel_tick)
  );

  assign lo_tick     = run && lo_sel_tick;
  assign lo_match_ev = lo_tick && lo_hit;

  tmr_src_sel #(.NTAP(NTAP), .SW(SW)) u_hi_sel (
    .sel(hi_src), .primary(lo_match_ev), .taps(tap_en), .tick(hi_sel_tick)
  );

  // In cascade mode the high count enable is the low carry-out.
  assign hi_tick     = casc ? lo_wrap : (run && hi_sel_tick);
  assign joint_match = casc && lo_tick && lo_hit && hi_hit;
  assign hi_match_ev = casc ? joint_match : (hi_tick && hi_hit);

  tmr_unit8 #(.CW(CW)) u_lo (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(lo_tick),
    .auto_rst(!casc), .force_clr(joint_match),
    .wr_en(lo_cmp_we), .wr_data(cmp_wdata),
    .cnt(lo_count), .cmp(lo_cmp_q), .hit(lo_hit), .wrap(lo_wrap)
  );

  tmr_unit8 #(.CW(CW)) u_hi (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(hi_tick),
    .auto_rst(!casc), .force_clr(joint_match),
    .wr_en(hi_cmp_we), .wr_data(cmp_wdata),
    .cnt(hi_count), .cmp(hi_cmp_q), .hit(hi_hit), .wrap(hi_wrap)
  );

  tmr_evt_out u_evt (
    .clk(clk), .rst_n(rst_n),
    .lo_evt(lo_match_ev && !casc), .hi_evt(hi_match_ev), .tff_en(tff_en),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .tff_q(tff_q)
  );

  logic unused_ok;
  assign unused_ok = hi_wrap;
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [1:0]    mode,
  input logic          lo_cmp_we,
  input logic          hi_cmp_we,
  input logic [CW-1:0] lo_cmp_q,
  input logic [CW-1:0] hi_cmp_q,
  input logic [CW-1:0] lo_count,
  input logic [CW-1:0] hi_count,
  input logic          irq_lo,
  input logic          irq_hi,
  input logic          tff_q
);
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (lo_count == '0 && hi_count == '0));

  a_r6_no_lo_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> !irq_lo);

  a_r2_lo_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (lo_count == '0));

  a_r7_hi_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (hi_count == '0));

  a_r8_tff_only_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tff_q) |-> irq_hi);

  a_r9_lo_cmp_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && lo_cmp_we) |=> $stable(lo_cmp_q));

  a_r9_hi_cmp_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hi_cmp_we) |=> $stable(hi_cmp_q));

  a_r5_hi_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b01 && !$stable(hi_count)) |-> (lo_count == '0));
endmodule

bind dual_tmr_top dual_tmr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
  .lo_cmp_we(lo_cmp_we), .hi_cmp_we(hi_cmp_we),
  .lo_cmp_q(lo_cmp_q), .hi_cmp_q(hi_cmp_q),
  .lo_count(lo_count), .hi_count(hi_count),
  .irq_lo(irq_lo), .irq_hi(irq_hi), .tff_q(tff_q)
);

// File: tb/dual_tmr_top_test.sv
module dual_tmr_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] lo_src = 2'd0;
  logic [1:0] hi_src = 2'd0;
  logic       ext_tick = 1'b0;
  logic [2:0] tap_en = 3'b000;
  logic       lo_cmp_we = 1'b0;
  logic       hi_cmp_we = 1'b0;
  logic [7:0] cmp_wdata = 8'h00;
  logic       tff_en = 1'b0;
  logic [7:0] lo_count, hi_count;
  logic       irq_lo, irq_hi, tff_q;

  int checks = 0;
  int errors = 0;
  int n_lo = 0;
  int n_hi = 0;
  bit done = 1'b0;

  dual_tmr_top uut (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
    .lo_src(lo_src), .hi_src(hi_src), .ext_tick(ext_tick), .tap_en(tap_en),
    .lo_cmp_we(lo_cmp_we), .hi_cmp_we(hi_cmp_we), .cmp_wdata(cmp_wdata),
    .tff_en(tff_en), .lo_count(lo_count), .hi_count(hi_count),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .tff_q(tff_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle of source activity, then tally the resulting pulses.
  task automatic step(input logic e, input logic [2:0] t);
    @(negedge clk);
    ext_tick = e;
    tap_en   = t;
    @(negedge clk);
    ext_tick = 1'b0;
    tap_en   = 3'b000;
    if (irq_lo) n_lo++;
    if (irq_hi) n_hi++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 3'b000);
  endtask

  task automatic wr_cmp(input bit hi, input logic [7:0] d);
    @(negedge clk);
    cmp_wdata = d;
    if (hi) hi_cmp_we = 1'b1; else lo_cmp_we = 1'b1;
    @(negedge clk);
    lo_cmp_we = 1'b0;
    hi_cmp_we = 1'b0;
  endtask

  task automatic stop_clear();
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    n_lo = 0;
    n_hi = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(lo_count == 0 && hi_count == 0, "R1 counts", lo_count + hi_count, 0);
    chk(!irq_lo && !irq_hi && !tff_q, "R1 outputs", irq_lo + irq_hi + tff_q, 0);
  endtask

  task automatic t_lo8();
    wr_cmp(1'b0, 8'd5);
    mode = 2'b00; lo_src = 2'd0; hi_src = 2'd1; run = 1'b1;
    ticks(3);
    chk(lo_count == 3, "R2 count", lo_count, 3);
    chk(n_lo == 0, "R2 no early irq", n_lo, 0);
    ticks(2);
    chk(lo_count == 0 && n_lo == 1, "R2 match reset", lo_count, 0);
    @(negedge clk);
    chk(!irq_lo, "R2 single cycle pulse", irq_lo, 0);
    ticks(10);
    chk(n_lo == 3, "R2 periodic", n_lo, 3);
    // write during run: period must stay 5
    wr_cmp(1'b0, 8'd2);
    ticks(4);
    chk(lo_count == 4 && n_lo == 3, "R9 write ignored", lo_count, 4);
    stop_clear();
  endtask

  task automatic t_idle();
    run = 1'b1;
    ticks(2);
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    chk(lo_count == 0, "R10 cleared", lo_count, 0);
    ticks(3);
    chk(lo_count == 0 && n_lo == 0, "R10 ticks ignored", lo_count, 0);
  endtask

  task automatic t_src();
    lo_src = 2'd2; mode = 2'b10; run = 1'b1;
    step(1'b1, 3'b101);
    step(1'b0, 3'b001);
    step(1'b0, 3'b100);
    chk(lo_count == 0, "R3 unselected ignored", lo_count, 0);
    step(1'b0, 3'b010);
    step(1'b0, 3'b010);
    step(1'b0, 3'b111);
    chk(lo_count == 3, "R3 tap1 selected", lo_count, 3);
    stop_clear();
    lo_src = 2'd0;
  endtask

  task automatic t_chain8();
    wr_cmp(1'b0, 8'd3);
    wr_cmp(1'b1, 8'd2);
    mode = 2'b00; hi_src = 2'd0; tff_en = 1'b1; run = 1'b1;
    ticks(5);
    chk(hi_count == 1 && n_hi == 0, "R4 hi counts lo matches", hi_count, 1);
    ticks(1);
    chk(hi_count == 0 && n_hi == 1, "R4 hi match", n_hi, 1);
    chk(tff_q == 1'b1, "R8 toggle", tff_q, 1);
    tff_en = 1'b0;
    ticks(6);
    chk(n_hi == 2 && tff_q == 1'b1, "R8 hold when disabled", tff_q, 1);
    chk(n_lo == 4, "R4 lo still independent", n_lo, 4);
    stop_clear();
  endtask

  task automatic t_casc16();
    wr_cmp(1'b0, 8'h80);
    wr_cmp(1'b1, 8'h04);
    mode = 2'b01; lo_src = 2'd0; hi_src = 2'd1; tff_en = 1'b1; run = 1'b1;
    // keep the tap that hi_src names active the whole time
    for (int i = 0; i < 'h81; i++) step(1'b1, 3'b001);
    chk(lo_count == 8'h81, "R6 lo passes own match", lo_count, 'h81);
    chk(hi_count == 0, "R5 hi ignores its source", hi_count, 0);
    for (int i = 0; i < 'h7F; i++) step(1'b1, 3'b001);
    chk(lo_count == 0 && hi_count == 1, "R5 carry", hi_count, 1);
    for (int i = 0; i < 'h37F; i++) step(1'b1, 3'b001);
    chk(hi_count == 4 && lo_count == 8'h7F, "R7 one tick before", lo_count, 'h7F);
    chk(n_hi == 0, "R7 no early irq", n_hi, 0);
    step(1'b1, 3'b001);
    chk(n_hi == 1 && lo_count == 0 && hi_count == 0, "R7 joint match", n_hi, 1);
    chk(n_lo == 0, "R6 no lo irq", n_lo, 0);
    chk(tff_q == 1'b0, "R8 toggle back", tff_q, 0);
    stop_clear();
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lo8();
    t_idle();
    t_src();
    t_chain8();
    t_casc16();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule